// File: doc/BRIEF.md
# Host Bus Command Port with Ready Flag

This block is the processor-facing side of a command-driven peripheral. A host uses four strobe-style control lines and an 8-bit data bus to see two byte locations. A write to location 0 sends one command byte to the command engine behind the port. A read of location 0 returns the output register, which holds the result of the last command that finished with a result. A read of location 1 returns a ready flag on data bit 3. The flag drops as soon as a command is accepted and rises again when the engine reports that the command is done.

All host strobes reach the core clock through multi-stage synchronizers. A command is taken on the release (rising edge) of the write strobe. A command that arrives while the port is busy is dropped and sets a sticky error bit. When a command completes, an active-low end-of-command output goes low for a fixed number of core cycles. That width is chosen so the pulse meets a 900 ns minimum, and the host can use the pulse as a completion interrupt. The data bus is split into input, output and output-enable, and the pad-level tri-state buffer sits outside this block.

Top module: `hostbus_port`

## Requirements
- R1: After reset the ready flag is 1, the output register is 0x00, `cmd_end_n` is 1, `cmd_err` is 0, and both `cmd_valid` and `host_doe` are 0.
- R2: A write strobe with `host_sel_n`=0 and `host_addr`=0 produces, on its release, exactly one single-cycle `cmd_valid` pulse carrying the byte on `host_din`.
- R3: A write with `host_addr`=1, or with `host_sel_n`=1, is ignored: no `cmd_valid`, and the ready flag stays 1.
- R4: A read with `host_addr`=1 returns the ready flag on bit 3, with every other bit 0 (0x08 ready, 0x00 busy).
- R5: The ready flag is 0 from the cycle a command is accepted until the cycle after `cmd_done` is seen, and is 1 from then on.
- R6: A legal write that arrives while the port is busy produces no `cmd_valid` and sets `cmd_err`, which stays 1 until reset.
- R7: When a busy port sees `cmd_done`, `cmd_end_n` goes low on the same edge that sets the flag to ready. It stays low for exactly `EOC_CYCLES` cycles and is 1 at all other times.
- R8: The output register takes `result_byte` only when `cmd_done` and `result_load` both arrive while the port is busy, and otherwise keeps its value. A read with `host_addr`=0 returns it.
- R9: `host_doe` is 1 only while both `host_sel_n` and `host_rd_n` are low (after synchronization). One of them alone never enables the bus.
- R10: `cmd_done` while the port is ready has no effect: there is no end-of-command pulse and the output register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_n | input | 1 | Port select, active low |
| host_addr | input | 1 | Location select: 0 data, 1 ready flag |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_din | input | DATA_W | Byte driven by the host |
| host_dout | output | DATA_W | Byte returned to the host |
| host_doe | output | 1 | Output enable for the external bus driver |
| cmd_valid | output | 1 | One-cycle pulse: new command byte |
| cmd_byte | output | DATA_W | Command byte for the engine |
| cmd_done | input | 1 | Engine reports the current command finished |
| result_load | input | 1 | With `cmd_done`: load `result_byte` into the output register |
| result_byte | input | DATA_W | Result of a finished query command |
| cmd_end_n | output | 1 | End-of-command pulse, active low |
| cmd_err | output | 1 | Sticky: a command was written while busy |

## Verification
The assertions assume that the host holds select, address and data steady for the whole write strobe and for at least two core cycles after the strobe is released. They also assume that only one strobe is active at a time and that `cmd_done` is a single-cycle pulse from the engine. The stimulus drives every input on the falling clock edge. It holds select, address and data for four cycles after each strobe is released and leaves several idle cycles between accesses. Each done pulse it issues lasts exactly one cycle.

// File: rtl/hostport_pkg.sv
`timescale 1ns/1ps
package hostport_pkg;
  localparam int HP_FLAG_BIT = 3;
  typedef enum logic {LOC_DATA = 1'b0, LOC_FLAG = 1'b1} hp_loc_e;
endpackage

// File: rtl/hp_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a group of independent asynchronous bits.
module hp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hp_write_capture.sv
`timescale 1ns/1ps
// Holds select/address/data while the synchronized write strobe is low and
// flags the strobe release as a write event.
module hp_write_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              addr_s,
  input  logic              wr_n_s,
  input  logic [DATA_W-1:0] din,
  output logic              wr_event,
  output logic              wr_legal,
  output logic [DATA_W-1:0] wr_byte
);
  import hostport_pkg::*;

  logic              wr_prev;
  logic              legal_q;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b1;
      legal_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      wr_prev <= wr_n_s;
      if (!wr_n_s) begin
        byte_q  <= din;
        legal_q <= !sel_n_s && (hp_loc_e'(addr_s) == LOC_DATA);
      end
    end
  end

  assign wr_event = wr_n_s && !wr_prev;
  assign wr_legal = legal_q;
  assign wr_byte  = byte_q;
endmodule

// File: rtl/hp_busy_ctrl.sv
`timescale 1ns/1ps
// Ready flag, command issue, sticky busy-write error, end-of-command timer.
module hp_busy_ctrl #(
  parameter int DATA_W = 8,
  parameter int EOC_CYCLES = 225
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_event,
  input  logic              wr_legal,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              cmd_done,
  output logic              ready_q,
  output logic              done_acc,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  output logic              cmd_err,
  output logic              cmd_end_n
);
  localparam int CNT_W = $clog2(EOC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EOC_CYCLES);

  logic             accept;
  logic             busy_hit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  assign accept   = wr_event && wr_legal && ready_q;
  assign busy_hit = wr_event && wr_legal && !ready_q;
  assign done_acc = cmd_done && !ready_q;

  always_comb begin
    if (done_acc)          cnt_next = CNT_LOAD;
    else if (cnt_q != '0)  cnt_next = cnt_q - 1'b1;
    else                   cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b1;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      cmd_err   <= 1'b0;
      cnt_q     <= '0;
      cmd_end_n <= 1'b1;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        cmd_byte <= wr_byte;
        ready_q  <= 1'b0;
      end else if (done_acc) begin
        ready_q  <= 1'b1;
      end
      if (busy_hit) cmd_err <= 1'b1;
      cnt_q     <= cnt_next;
      cmd_end_n <= (cnt_next == '0);
    end
  end
endmodule

// File: rtl/hp_read_port.sv
`timescale 1ns/1ps
// Output register and registered read-data / output-enable path.
module hp_read_port #(
  parameter int DATA_W = 8,
  parameter int FLAG_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              rd_n_s,
  input  logic              addr_s,
  input  logic              ready_q,
  input  logic              done_acc,
  input  logic              result_load,
  input  logic [DATA_W-1:0] result_byte,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);
  import hostport_pkg::*;

  logic [DATA_W-1:0] flag_word;

  always_comb begin
    flag_word = '0;
    flag_word[FLAG_BIT] = ready_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dout  <= '0;
      doe   <= 1'b0;
    end else begin
      if (done_acc && result_load) out_q <= result_byte;
      dout <= (hp_loc_e'(addr_s) == LOC_FLAG) ? flag_word : out_q;
      doe  <= !sel_n_s && !rd_n_s;
    end
  end
endmodule

// File: rtl/hostbus_port.sv
`timescale 1ns/1ps
module hostbus_port #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int EOC_CYCLES = 225
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel_n,
  input  logic              host_addr,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_doe,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_done,
  input  logic              result_load,
  input  logic [DATA_W-1:0] result_byte,
  output logic              cmd_end_n,
  output logic              cmd_err
);
  import hostport_pkg::*;

  logic [2:0]        strobes_s;
  logic              addr_s;
  logic              wr_event;
  logic              wr_legal;
  logic [DATA_W-1:0] wr_byte;
  logic              ready_q;
  logic              done_acc;
  logic [DATA_W-1:0] out_q;

  hp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strb (
    .clk(clk), .rst(rst),
    .d_async({host_sel_n, host_rd_n, host_wr_n}),
    .q_sync(strobes_s)
  );

  hp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_addr (
    .clk(clk), .rst(rst), .d_async(host_addr), .q_sync(addr_s)
  );

  hp_write_capture #(.DATA_W(DATA_W)) u_wcap (
    .clk(clk), .rst(rst),
    .sel_n_s(strobes_s[2]), .addr_s(addr_s), .wr_n_s(strobes_s[0]),
    .din(host_din),
    .wr_event(wr_event), .wr_legal(wr_legal), .wr_byte(wr_byte)
  );

  hp_busy_ctrl #(.DATA_W(DATA_W), .EOC_CYCLES(EOC_CYCLES)) u_busy (
    .clk(clk), .rst(rst),
    .wr_event(wr_event), .wr_legal(wr_legal), .wr_byte(wr_byte),
    .cmd_done(cmd_done),
    .ready_q(ready_q), .done_acc(done_acc),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_err(cmd_err), .cmd_end_n(cmd_end_n)
  );

  hp_read_port #(.DATA_W(DATA_W), .FLAG_BIT(HP_FLAG_BIT)) u_rd (
    .clk(clk), .rst(rst),
    .sel_n_s(strobes_s[2]), .rd_n_s(strobes_s[1]), .addr_s(addr_s),
    .ready_q(ready_q), .done_acc(done_acc),
    .result_load(result_load), .result_byte(result_byte),
    .out_q(out_q), .dout(host_dout), .doe(host_doe)
  );
endmodule

// File: rtl/hostbus_port_chk.sv
`timescale 1ns/1ps
module hostbus_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              ready_q,
  input logic              cmd_err,
  input logic              cmd_end_n,
  input logic              cmd_done,
  input logic              result_load,
  input logic [DATA_W-1:0] out_q
);
  // R2
  cmd_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R5
  busy_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !ready_q);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);

  // R7
  eoc_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_end_n) |-> ready_q);

  // R10
  idle_done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && cmd_done && cmd_end_n) |=> cmd_end_n);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q || !cmd_done || !result_load) |=> $stable(out_q));
endmodule

bind hostbus_port hostbus_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .ready_q(ready_q),
  .cmd_err(cmd_err), .cmd_end_n(cmd_end_n), .cmd_done(cmd_done),
  .result_load(result_load), .out_q(out_q)
);

// File: tb/hostbus_port_tb.sv
`timescale 1ns/1ps
module hostbus_port_tb;
  localparam int DW = 8;
  localparam int EOC_N = 225;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel_n = 1'b1, host_addr = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [DW-1:0] host_din = '0;
  logic [DW-1:0] host_dout;
  logic host_doe, cmd_valid, cmd_end_n, cmd_err;
  logic [DW-1:0] cmd_byte;
  logic cmd_done = 1'b0, result_load = 1'b0;
  logic [DW-1:0] result_byte = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] rd_exp[$];
  string         rd_tag[$];
  logic [DW-1:0] cmd_exp[$];

  always #2 clk = ~clk;

  hostbus_port #(.DATA_W(DW), .SYNC_STAGES(2), .EOC_CYCLES(EOC_N)) u_dut (
    .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .cmd_done(cmd_done), .result_load(result_load),
    .result_byte(result_byte), .cmd_end_n(cmd_end_n), .cmd_err(cmd_err)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Monitor: compares read data and issued commands against the scoreboard.
  initial begin
    logic oe_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (host_doe && !oe_prev) begin
          if (rd_exp.size() == 0) check("R9 unexpected bus enable", 8'h01, 8'h00);
          else check(rd_tag.pop_front(), host_dout, rd_exp.pop_front());
        end
        if (cmd_valid) begin
          if (cmd_exp.size() == 0) check("R2 unexpected command pulse", cmd_byte, 8'hxx);
          else check("R2 command byte", cmd_byte, cmd_exp.pop_front());
        end
      end
      oe_prev = host_doe;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_read(input logic addr, input logic [DW-1:0] exp, input string tag);
    rd_exp.push_back(exp);
    rd_tag.push_back(tag);
    @(negedge clk);
    host_sel_n = 1'b0; host_addr = addr; host_rd_n = 1'b0;
    idle(5);
    host_rd_n = 1'b1; host_sel_n = 1'b1;
    idle(5);
  endtask

  task automatic host_write(input logic sel_n, input logic addr, input logic [DW-1:0] b,
                            input bit expect_cmd);
    if (expect_cmd) cmd_exp.push_back(b);
    @(negedge clk);
    host_sel_n = sel_n; host_addr = addr; host_din = b; host_wr_n = 1'b0;
    idle(3);
    host_wr_n = 1'b1;
    idle(4);
    host_sel_n = 1'b1; host_addr = 1'b0;
    idle(3);
  endtask

  // Engine completes; returns number of cycles the end pulse was low.
  task automatic engine_done(input logic load, input logic [DW-1:0] b, output int low_n);
    @(negedge clk);
    cmd_done = 1'b1; result_load = load; result_byte = b;
    @(negedge clk);
    cmd_done = 1'b0; result_load = 1'b0;
    low_n = 0;
    while (!cmd_end_n && low_n < 1000) begin
      low_n++;
      @(negedge clk);
    end
    idle(2);
  endtask

  initial begin
    int n;
    idle(5);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1 cmd_end_n", {7'b0, cmd_end_n}, 8'h01);
    check("R1 cmd_err",   {7'b0, cmd_err},   8'h00);
    check("R1 cmd_valid", {7'b0, cmd_valid}, 8'h00);
    check("R1 host_doe",  {7'b0, host_doe},  8'h00);
    host_read(1'b1, 8'h08, "R1 R4 ready flag after reset");
    host_read(1'b0, 8'h00, "R1 output register after reset");

    // R2, R5, R7: command without result
    host_write(1'b0, 1'b0, 8'h4D, 1'b1);
    host_read(1'b1, 8'h00, "R5 R4 flag busy");
    check("R7 no pulse while busy", {7'b0, cmd_end_n}, 8'h01);
    engine_done(1'b0, 8'hEE, n);
    check("R7 end pulse width", n[7:0], 8'(EOC_N));
    host_read(1'b1, 8'h08, "R5 flag ready after done");
    host_read(1'b0, 8'h00, "R8 no load without result_load");

    // R8: query command with result
    host_write(1'b0, 1'b0, 8'hEA, 1'b1);
    engine_done(1'b1, 8'h5A, n);
    check("R7 end pulse width 2", n[7:0], 8'(EOC_N));
    host_read(1'b0, 8'h5A, "R8 result loaded");

    // R2: several byte patterns
    foreach (cmd_exp[i]) begin end
    for (int k = 0; k < 3; k++) begin
      logic [DW-1:0] pat;
      pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'hA5;
      host_write(1'b0, 1'b0, pat, 1'b1);
      engine_done(1'b0, 8'h00, n);
    end
    host_read(1'b0, 8'h5A, "R8 register kept over non-result commands");

    // R3: illegal writes ignored
    host_write(1'b0, 1'b1, 8'h33, 1'b0);
    host_read(1'b1, 8'h08, "R3 write to flag location ignored");
    host_write(1'b1, 1'b0, 8'h44, 1'b0);
    host_read(1'b1, 8'h08, "R3 write without select ignored");
    check("R3 no error from ignored writes", {7'b0, cmd_err}, 8'h00);

    // R6: write while busy
    host_write(1'b0, 1'b0, 8'h80, 1'b1);
    host_write(1'b0, 1'b0, 8'h81, 1'b0);
    check("R6 sticky error set", {7'b0, cmd_err}, 8'h01);
    host_read(1'b1, 8'h00, "R6 still busy");
    engine_done(1'b1, 8'hC3, n);
    host_read(1'b0, 8'hC3, "R6 R8 result of first command");
    check("R6 error stays set", {7'b0, cmd_err}, 8'h01);

    // R10: done while idle
    @(negedge clk);
    cmd_done = 1'b1; result_load = 1'b1; result_byte = 8'h11;
    @(negedge clk);
    cmd_done = 1'b0; result_load = 1'b0;
    begin
      int lows = 0;
      for (int k = 0; k < 6; k++) begin
        if (!cmd_end_n) lows++;
        @(negedge clk);
      end
      check("R10 no end pulse when idle", lows[7:0], 8'h00);
    end
    host_read(1'b0, 8'hC3, "R10 output register unchanged");
    host_read(1'b1, 8'h08, "R10 flag still ready");

    // R9: select alone / read alone never enables
    begin
      int en = 0;
      @(negedge clk);
      host_sel_n = 1'b0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (host_doe) en++; end
      host_sel_n = 1'b1; host_rd_n = 1'b0;
      for (int k = 0; k < 6; k++) begin @(negedge clk); if (host_doe) en++; end
      host_rd_n = 1'b1;
      check("R9 bus enable needs select and read", en[7:0], 8'h00);
    end

    idle(5);
    check("R2 all expected commands seen", 8'(cmd_exp.size()), 8'h00);
    check("R9 all expected reads seen", 8'(rd_exp.size()), 8'h00);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule